// File: doc/BRIEF.md
# Modulo-Counter Pulse-Width Modulator

This block produces a pulse-width modulated output from an up-counter that advances on a prescaler enable strobe and one compare channel. The counter climbs from zero to a programmed modulo value and wraps back to zero on the next enabled cycle. The wrap is the overflow, and the period is the modulo value plus one enabled cycles. At overflow the output goes to its active level. When the counter reaches the compare value, the output returns to its inactive level, so the compare value sets the pulse width directly in enabled cycles.

One polarity input chooses between two pulse types. With polarity 0 the pulse is active-high: the pin is driven high at overflow and cleared at compare. With polarity 1 the pulse is active-low: the pin is driven low at overflow and set at compare. The modulo, compare and polarity inputs go through shadow registers that load only at overflow. A change of settings therefore never cuts a running period short. The prescaler that generates the enable strobe lies outside this block.

Top module: `pwm_modulo_gen`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the counter is cleared and the shadow modulo and compare values are cleared. The output goes to the inactive level of `polarity_i`: 0 when `polarity_i` is 0, 1 when `polarity_i` is 1. The first enabled cycle after reset is therefore an overflow.
- R2: The counter and the output change only at clock edges where `tick_en` is 1.
- R3: On enabled cycles the counter steps 0, 1, … up to the shadow modulo value M, then wraps to 0. One period is M+1 enabled cycles, including M = 0.
- R4: `modulo_i`, `compare_i` and `polarity_i` are sampled into the shadow registers only at an overflow. Changes made mid-period take effect from the next period.
- R5: At an overflow whose new compare value is nonzero, the output goes to its active level.
- R6: The output stays active for the enabled cycles in which the counter holds 0 … C−1. It goes inactive at the enabled edge where the counter reaches C, so the pulse lasts C enabled cycles. With C = M the duty is M/(M+1).
- R7: The output is the active state XOR the shadow polarity. Polarity 0 gives active-high pulses and polarity 1 gives active-low pulses.
- R8: A compare value of 0 gives an output held at the inactive level for the whole period (0 % duty).
- R9: A compare value greater than the modulo value never matches. The output then stays at the active level for the whole period (100 % duty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Prescaler enable strobe; counter advances when high |
| modulo_i | input | W | Modulo value (period − 1), loaded at overflow |
| compare_i | input | W | Compare value (pulse width), loaded at overflow |
| polarity_i | input | 1 | 0 = active-high pulse, 1 = active-low pulse |
| pwm_o | output | 1 | Modulated output |

## Verification
A counter that wraps at the wrong value or steps on a cycle without the strobe shifts the next overflow. The output then shows it as an edge one or more enabled cycles early or late, within one period. A shadow register that loads outside overflow changes the pulse width or period in the middle of a period. The bench compares the output on every clock with a behavioural model, so such a mismatch is caught on the first cycle where the edge moves. A wrong active flag or polarity inverts the output level and is flagged on the very next clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic {
        POL_ACT_HIGH = 1'b0,
        POL_ACT_LOW  = 1'b1
    } pol_e;

    // pin level for a given active state under a given polarity
    function automatic logic drive_level(input logic active, input pol_e pol);
        return active ^ logic'(pol);
    endfunction

endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_nx_o,
    output logic         wrap_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_s;

    ctr_s st_d, st_q;
    logic wrap;

    always_comb begin
        st_d = st_q;
        wrap = !rst && tick && (st_q.cnt == lim);
        if (rst) begin
            st_d.cnt = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign cnt_nx_o = st_d.cnt;
    assign wrap_o   = wrap;

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] per_i,
    input  logic [W-1:0] cmp_i,
    input  pol_e         pol_i,
    output logic [W-1:0] per_o,
    output logic [W-1:0] cmp_o,
    output pol_e         pol_o
);

    typedef struct packed {
        logic [W-1:0] per;
        logic [W-1:0] cmp;
        pol_e         pol;
    } shd_s;

    shd_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.per = '0;
            st_d.cmp = '0;
            st_d.pol = pol_i;
        end else if (load) begin
            st_d.per = per_i;
            st_d.cmp = cmp_i;
            st_d.pol = pol_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign per_o = st_q.per;
    assign cmp_o = st_q.cmp;
    assign pol_o = st_q.pol;

endmodule

// File: rtl/pwm_level.sv
module pwm_level #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wrap,
    input  logic [W-1:0] cnt_nx,
    input  logic [W-1:0] cmp_eff,
    output logic         act_o
);

    typedef struct packed {
        logic act;
    } lvl_s;

    lvl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.act = 1'b0;
        end else if (wrap) begin
            // set at overflow unless the new width is zero
            st_d.act = (cmp_eff != '0);
        end else if (tick && (cnt_nx == cmp_eff)) begin
            st_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign act_o = st_q.act;

endmodule

// File: rtl/pwm_modulo_gen.sv
module pwm_modulo_gen
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic [W-1:0] modulo_i,
    input  logic [W-1:0] compare_i,
    input  logic         polarity_i,
    output logic         pwm_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nx;
    logic         wrap;
    logic [W-1:0] per_q;
    logic [W-1:0] cmp_q;
    pol_e         pol_q;
    logic [W-1:0] cmp_eff;
    logic         act_q;

    pwm_period_ctr #(.W(W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_en),
        .lim      (per_q),
        .cnt_o    (cnt_q),
        .cnt_nx_o (cnt_nx),
        .wrap_o   (wrap)
    );

    pwm_shadow #(.W(W)) u_shd (
        .clk   (clk),
        .rst   (rst),
        .load  (wrap),
        .per_i (modulo_i),
        .cmp_i (compare_i),
        .pol_i (pol_e'(polarity_i)),
        .per_o (per_q),
        .cmp_o (cmp_q),
        .pol_o (pol_q)
    );

    // the compare used this cycle: the incoming one at overflow
    assign cmp_eff = wrap ? compare_i : cmp_q;

    pwm_level #(.W(W)) u_lvl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_en),
        .wrap    (wrap),
        .cnt_nx  (cnt_nx),
        .cmp_eff (cmp_eff),
        .act_o   (act_q)
    );

    assign pwm_o = drive_level(act_q, pol_q);

endmodule

// File: rtl/pwm_modulo_gen_chk.sv
module pwm_modulo_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick_en,
    input logic [W-1:0] modulo_i,
    input logic [W-1:0] compare_i,
    input logic         pwm_o,
    input logic [W-1:0] cnt,
    input logic [W-1:0] per,
    input logic [W-1:0] cmp,
    input logic         pol,
    input logic         wrap
);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= per);                                                    // R3

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(cnt) && $stable(pwm_o)));                 // R2

    AST_WRAP_LOADS: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0 && per == $past(modulo_i) && cmp == $past(compare_i))); // R4

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> ($stable(per) && $stable(cmp) && $stable(pol)));      // R4

    AST_WRAP_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (wrap && compare_i != '0) |=> (pwm_o != pol));                  // R5

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
        (wrap && compare_i == '0) |=> (pwm_o == pol));                  // R8

    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (rst)
        (!wrap && cmp > per) |=> $stable(pwm_o));                       // R9

endmodule

bind pwm_modulo_gen pwm_modulo_gen_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .modulo_i  (modulo_i),
    .compare_i (compare_i),
    .pwm_o     (pwm_o),
    .cnt       (cnt_q),
    .per       (per_q),
    .cmp       (cmp_q),
    .pol       (pol_q),
    .wrap      (wrap)
);

// File: tb/pwm_modulo_gen_tb.sv
module pwm_modulo_gen_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_en = 1'b0;
    logic [W-1:0] modulo_i = '0;
    logic [W-1:0] compare_i = '0;
    logic         polarity_i = 1'b0;
    logic         pwm_o;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    int m_cnt, m_per, m_cmp, m_pol, m_act;

    always #2 clk = ~clk;

    pwm_modulo_gen #(.W(W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .modulo_i   (modulo_i),
        .compare_i  (compare_i),
        .polarity_i (polarity_i),
        .pwm_o      (pwm_o)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pwm_o=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // model of what the next clock edge does with the inputs now applied
    task automatic model_edge();
        if (rst) begin
            m_cnt = 0; m_per = 0; m_cmp = 0; m_pol = int'(polarity_i); m_act = 0;
        end else if (tick_en) begin
            if (m_cnt == m_per) begin
                m_cnt = 0;
                m_per = int'(modulo_i);
                m_cmp = int'(compare_i);
                m_pol = int'(polarity_i);
                m_act = (m_cmp != 0) ? 1 : 0;
            end else begin
                m_cnt++;
                if (m_cnt == m_cmp) m_act = 0;
            end
        end
    endtask

    task automatic step(input logic t, input string tag);
        tick_en = t;
        model_edge();
        @(negedge clk);
        check(pwm_o, logic'(m_act[0] ^ m_pol[0]), tag);
    endtask

    task automatic run(input int n, input int every, input string tag);
        for (int i = 0; i < n; i++) step((i % every) == 0, tag);
    endtask

    // counts output samples equal to lvl over n enabled cycles
    task automatic count_level(input int n, input logic lvl, input int exp, input string tag);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            step(1'b1, tag);
            if (pwm_o == lvl) hits++;
        end
        n_chk++;
        if (hits != exp) begin
            n_fail++;
            $display("FAIL %s: level count=%0d expected %0d", tag, hits, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1'b1; polarity_i = 1'b0; modulo_i = 8'd9; compare_i = 8'd3;
        step(1'b0, "R1");
        step(1'b1, "R1");
        check(pwm_o, 1'b0, "R1");
        rst = 1'b0;
        run(40, 1, "R3");
        count_level(10, 1'b1, 3, "R6");
        run(60, 3, "R2");
        run(7, 1, "R2");
        modulo_i = 8'd4; compare_i = 8'd2;       // applied mid-period
        run(7, 1, "R4");
        run(20, 1, "R4");
        polarity_i = 1'b1;
        run(20, 1, "R7");
        count_level(5, 1'b0, 2, "R7");
        compare_i = 8'd0;
        run(20, 1, "R8");
        count_level(5, 1'b0, 0, "R8");
        polarity_i = 1'b0; compare_i = 8'd12;
        run(20, 1, "R9");
        count_level(5, 1'b1, 5, "R9");
        compare_i = 8'd4;
        run(20, 2, "R6");
        count_level(5, 1'b1, 4, "R6");
        modulo_i = 8'd0; compare_i = 8'd1;
        run(10, 1, "R3");
        compare_i = 8'd0;
        run(10, 1, "R8");
        modulo_i = 8'd255; compare_i = 8'd128;
        run(600, 1, "R5");
        polarity_i = 1'b1; rst = 1'b1;
        step(1'b1, "R1");
        check(pwm_o, 1'b1, "R1");
        rst = 1'b0; modulo_i = 8'd6; compare_i = 8'd2;
        run(30, 1, "R5");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule